// File: doc/BRIEF.md
# Ethernet DMA Controller Register Bank

This block is the software-visible control and status register bank of an Ethernet DMA controller. It decodes a 4 KB window of 32-bit word registers and gives each register an access class: read-write, write-only, write-1-to-clear, read-only, or unknown. The class decides what a read returns and what a write does. A few registers carry side effects on write. Ring base writes are copied into the matching ring pointer. Writes to the transmit and receive halt status registers clear bits and also issue per-ring kick pulses. Writes to the interrupt event register lower the interrupt lines.

The descriptor ring walkers and the MAC data path sit next to this block. They take the one-cycle kick pulses and report events through the set inputs: the halt set vectors and the event set vector. Three interrupt lines go to the interrupt controller: transmit, receive and error. A write takes effect at the next rising clock edge. Read data is combinational from the address and the stored state.

Top module: `enet_csr_bank`

## Requirements
- R1: The register index is `csr_addr[11:2]`. Address bits [1:0] have no effect, so every access is a whole 32-bit word.
- R2: The command register (index 3) is write-only. It always reads zero. A write stores the data, and the stored value is driven on `cmd_word`.
- R3: The control register (index 2), the event enable register (index 1) and the ring pointers (indexes 16..23 and 32..39) are read-write. The identity register (index 4) is read-only and ignores writes. Any index not defined here reads zero and ignores writes.
- R4: The sticky status register (index 5) is write-1-to-clear. A write clears each bit written as 1 and leaves the other bits unchanged.
- R5: A write to a transmit ring base (index 8+i) or a receive ring base (index 24+i) stores the data with bits [2:0] forced to zero. The same write puts the same value into that ring's pointer (index 16+i or 32+i).
- R6: In the transmit halt register (index 6), bit 31-i belongs to ring i. Writing 1 to that bit pulses `tx_kick[i]` for exactly the cycle after the write, whatever the bit held before. Bits written as 1 are cleared. `tx_halt_set[i]` sets bit 31-i.
- R7: In the receive halt register (index 7), bit 23-i belongs to ring i. `rx_kick[i]` pulses in the cycle after a write only if a 1 is written to that bit while it is 0. Bits written as 1 are cleared. `rx_halt_set[i]` sets bit 23-i.
- R8: The event register (index 0) is write-1-to-clear. `evt_set` ORs into it on every clock. When a set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R9: Bit 0 is the transmit-frame event and bit 1 is the receive-frame event. `irq_tx` (or `irq_rx`) rises in the cycle after that event is set while the same bit of the enable register is 1. It falls only after an event write that leaves the event bit clear.
- R10: Bits [12:2] are error events. `irq_err` rises in the cycle after any of them is set with its enable bit at 1. It falls only after an event write that leaves all of bits [12:2] clear, masked bits included. Bits [31:13] drive no interrupt.
- R11: After reset, control reads 0x00000040, identity reads 0x5E7C0001, sticky status reads 0x0000FFFF, and every other register, kick and interrupt is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | Access strobe |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | Byte address in the 4 KB window |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr` |
| evt_set | input | 32 | Event set pulses from the data path |
| tx_halt_set | input | NUM_RINGS | Transmit ring halted, one bit per ring |
| rx_halt_set | input | NUM_RINGS | Receive ring halted, one bit per ring |
| tx_kick | output | NUM_RINGS | One-cycle restart pulse per transmit ring |
| rx_kick | output | NUM_RINGS | One-cycle restart pulse per receive ring |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |
| ctrl_word | output | 32 | Control register contents |
| cmd_word | output | 32 | Command register contents |

## Verification
The assertions check on every cycle the following invariants. A transmit kick always follows a write to the transmit halt register. A receive kick only follows a halt bit that was 0. The transmit interrupt only falls after an event write. The error interrupt only falls when all error events are clear. A hardware event set is never lost to a same-cycle clear. The bench's scenarios alone can show exact stored values and alignment, the read masking of write-only and unknown registers, and the copy of a base into its pointer. They also show masked events, the error line held up by a masked error bit, and the exact pulse patterns under chosen halt states.

// File: rtl/enet_csr_pkg.sv
package enet_csr_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_RW,
    ACC_WO,
    ACC_W1C,
    ACC_RO
  } acc_e;

  typedef logic [9:0] idx_t;

  localparam int   SLOTS      = 8;
  localparam idx_t IDX_EVT    = 10'd0;
  localparam idx_t IDX_EVEN   = 10'd1;
  localparam idx_t IDX_CTRL   = 10'd2;
  localparam idx_t IDX_CMD    = 10'd3;
  localparam idx_t IDX_ID     = 10'd4;
  localparam idx_t IDX_STICKY = 10'd5;
  localparam idx_t IDX_TXHALT = 10'd6;
  localparam idx_t IDX_RXHALT = 10'd7;
  localparam idx_t IDX_TXBASE = 10'd8;
  localparam idx_t IDX_TXPTR  = 10'd16;
  localparam idx_t IDX_RXBASE = 10'd24;
  localparam idx_t IDX_RXPTR  = 10'd32;

  localparam int TX_HALT_TOP = 31;
  localparam int RX_HALT_TOP = 23;

  localparam logic [31:0] EVT_TXF = 32'h0000_0001;
  localparam logic [31:0] EVT_RXF = 32'h0000_0002;
  localparam logic [31:0] EVT_ERR = 32'h0000_1FFC;

  // Value left by a plain write for a given access class
  function automatic logic [31:0] cell_next(acc_e kind, logic [31:0] cur, logic [31:0] wd);
    case (kind)
      ACC_RW, ACC_WO: return wd;
      ACC_W1C:        return cur & ~wd;
      default:        return cur;
    endcase
  endfunction

  // What software sees when reading a register of a given class
  function automatic logic [31:0] read_view(acc_e kind, logic [31:0] cur);
    return (kind == ACC_WO || kind == ACC_NONE) ? 32'h0 : cur;
  endfunction

  function automatic logic [31:0] align8(logic [31:0] d);
    return {d[31:3], 3'b000};
  endfunction

  // Bits top, top-1, ... top-(n-1) set
  function automatic logic [31:0] halt_field(int top, int n);
    logic [31:0] m = '0;
    for (int i = 0; i < n; i++) m[top - i] = 1'b1;
    return m;
  endfunction

  // Clear then set: a set wins over a clear of the same bit
  function automatic logic [31:0] evt_apply(logic [31:0] cur, logic [31:0] clr, logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_next(logic cur, logic raise, logic lower);
    return (cur | raise) & ~lower;
  endfunction

endpackage

// File: rtl/enet_csr_cell.sv
module enet_csr_cell
  import enet_csr_pkg::*;
#(
  parameter acc_e        KIND = ACC_RW,
  parameter logic [31:0] RST  = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] q,
  output logic [31:0] rview
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST;
    else if (wr) q <= cell_next(KIND, q, wdata);
  end

  assign rview = read_view(KIND, q);

endmodule

// File: rtl/enet_csr_ring_bank.sv
module enet_csr_ring_bank
  import enet_csr_pkg::*;
#(
  parameter int   NUM_RINGS = 8,
  parameter idx_t BASE_IDX  = IDX_TXBASE,
  parameter idx_t PTR_IDX   = IDX_TXPTR
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  idx_t                  idx,
  input  logic [31:0]           wdata,
  output logic [SLOTS-1:0][31:0] base_q,
  output logic [SLOTS-1:0][31:0] ptr_q
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < NUM_RINGS) begin : g_live
      logic base_hit, ptr_hit;
      assign base_hit = wr && (idx == BASE_IDX + idx_t'(s));
      assign ptr_hit  = wr && (idx == PTR_IDX + idx_t'(s));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          base_q[s] <= '0;
          ptr_q[s]  <= '0;
        end else if (base_hit) begin
          base_q[s] <= align8(wdata);
          ptr_q[s]  <= align8(wdata);
        end else if (ptr_hit) begin
          ptr_q[s]  <= wdata;
        end
      end
    end else begin : g_absent
      assign base_q[s] = '0;
      assign ptr_q[s]  = '0;
    end
  end

endmodule

// File: rtl/enet_csr_halt.sv
module enet_csr_halt
  import enet_csr_pkg::*;
#(
  parameter int NUM_RINGS = 8,
  parameter int TOP_BIT   = 31,
  parameter bit EDGE_ONLY = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [31:0]          wdata,
  input  logic [NUM_RINGS-1:0] hw_set,
  output logic [31:0]          stat_q,
  output logic [NUM_RINGS-1:0] kick
);

  localparam logic [31:0] HMASK = halt_field(TOP_BIT, NUM_RINGS);

  logic [31:0]          set_vec;
  logic [31:0]          clr_vec;
  logic [NUM_RINGS-1:0] kick_d;

  always_comb begin
    set_vec = '0;
    kick_d  = '0;
    for (int i = 0; i < NUM_RINGS; i++) begin
      set_vec[TOP_BIT - i] = hw_set[i];
      kick_d[i] = wr && wdata[TOP_BIT - i] && (!EDGE_ONLY || !stat_q[TOP_BIT - i]);
    end
    clr_vec = wr ? wdata : 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      kick   <= '0;
    end else begin
      stat_q <= evt_apply(stat_q, clr_vec, set_vec) & HMASK;
      kick   <= kick_d;
    end
  end

endmodule

// File: rtl/enet_csr_events.sv
module enet_csr_events
  import enet_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic [31:0] set,
  input  logic [31:0] enable,
  output logic [31:0] evt_q,
  output logic        irq_tx,
  output logic        irq_rx,
  output logic        irq_err
);

  logic [31:0] evt_d;
  logic raise_tx, raise_rx, raise_err;
  logic lower_tx, lower_rx, lower_err;

  assign evt_d     = evt_apply(evt_q, wr ? wdata : 32'h0, set);
  assign raise_tx  = |(set & enable & EVT_TXF);
  assign raise_rx  = |(set & enable & EVT_RXF);
  assign raise_err = |(set & enable & EVT_ERR);
  assign lower_tx  = wr && ((evt_d & EVT_TXF) == 32'h0);
  assign lower_rx  = wr && ((evt_d & EVT_RXF) == 32'h0);
  assign lower_err = wr && ((evt_d & EVT_ERR) == 32'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q   <= '0;
      irq_tx  <= 1'b0;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      evt_q   <= evt_d;
      irq_tx  <= irq_next(irq_tx, raise_tx, lower_tx);
      irq_rx  <= irq_next(irq_rx, raise_rx, lower_rx);
      irq_err <= irq_next(irq_err, raise_err, lower_err);
    end
  end

endmodule

// File: rtl/enet_csr_bank.sv
module enet_csr_bank
  import enet_csr_pkg::*;
#(
  parameter int          NUM_RINGS  = 8,
  parameter logic [31:0] CTRL_RST   = 32'h0000_0040,
  parameter logic [31:0] ID_VALUE   = 32'h5E7C_0001,
  parameter logic [31:0] STICKY_RST = 32'h0000_FFFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_en,
  input  logic                 csr_we,
  input  logic [11:0]          csr_addr,
  input  logic [31:0]          csr_wdata,
  output logic [31:0]          csr_rdata,
  input  logic [31:0]          evt_set,
  input  logic [NUM_RINGS-1:0] tx_halt_set,
  input  logic [NUM_RINGS-1:0] rx_halt_set,
  output logic [NUM_RINGS-1:0] tx_kick,
  output logic [NUM_RINGS-1:0] rx_kick,
  output logic                 irq_tx,
  output logic                 irq_rx,
  output logic                 irq_err,
  output logic [31:0]          ctrl_word,
  output logic [31:0]          cmd_word
);

  localparam int NCELL = 5;
  localparam idx_t        CELL_IDX [NCELL] = '{IDX_EVEN, IDX_CTRL, IDX_CMD, IDX_ID, IDX_STICKY};
  localparam acc_e        CELL_ACC [NCELL] = '{ACC_RW, ACC_RW, ACC_WO, ACC_RO, ACC_W1C};
  localparam logic [31:0] CELL_RST [NCELL] = '{32'h0, CTRL_RST, 32'h0, ID_VALUE, STICKY_RST};

  idx_t        idx;
  logic        wr;
  logic        unused_lsb;
  logic [31:0] cell_q [NCELL];
  logic [31:0] cell_rv[NCELL];
  logic [31:0] evt_q;
  logic [31:0] tx_stat_q, rx_stat_q;
  logic [SLOTS-1:0][31:0] tx_base, tx_ptr, rx_base, rx_ptr;

  assign idx        = csr_addr[11:2];
  assign unused_lsb = ^csr_addr[1:0];
  assign wr         = csr_en && csr_we;

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    enet_csr_cell #(.KIND(CELL_ACC[c]), .RST(CELL_RST[c])) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr && (idx == CELL_IDX[c])),
      .wdata (csr_wdata),
      .q     (cell_q[c]),
      .rview (cell_rv[c])
    );
  end

  assign ctrl_word = cell_q[1];
  assign cmd_word  = cell_q[2];

  enet_csr_events u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr && (idx == IDX_EVT)),
    .wdata   (csr_wdata),
    .set     (evt_set),
    .enable  (cell_q[0]),
    .evt_q   (evt_q),
    .irq_tx  (irq_tx),
    .irq_rx  (irq_rx),
    .irq_err (irq_err)
  );

  enet_csr_halt #(.NUM_RINGS(NUM_RINGS), .TOP_BIT(TX_HALT_TOP), .EDGE_ONLY(1'b0)) u_txh (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr && (idx == IDX_TXHALT)),
    .wdata  (csr_wdata),
    .hw_set (tx_halt_set),
    .stat_q (tx_stat_q),
    .kick   (tx_kick)
  );

  enet_csr_halt #(.NUM_RINGS(NUM_RINGS), .TOP_BIT(RX_HALT_TOP), .EDGE_ONLY(1'b1)) u_rxh (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr && (idx == IDX_RXHALT)),
    .wdata  (csr_wdata),
    .hw_set (rx_halt_set),
    .stat_q (rx_stat_q),
    .kick   (rx_kick)
  );

  enet_csr_ring_bank #(.NUM_RINGS(NUM_RINGS), .BASE_IDX(IDX_TXBASE), .PTR_IDX(IDX_TXPTR)) u_txr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr),
    .idx    (idx),
    .wdata  (csr_wdata),
    .base_q (tx_base),
    .ptr_q  (tx_ptr)
  );

  enet_csr_ring_bank #(.NUM_RINGS(NUM_RINGS), .BASE_IDX(IDX_RXBASE), .PTR_IDX(IDX_RXPTR)) u_rxr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr),
    .idx    (idx),
    .wdata  (csr_wdata),
    .base_q (rx_base),
    .ptr_q  (rx_ptr)
  );

  always_comb begin
    csr_rdata = 32'h0;
    for (int c = 0; c < NCELL; c++)
      if (idx == CELL_IDX[c]) csr_rdata = cell_rv[c];
    if (idx == IDX_EVT)    csr_rdata = evt_q;
    if (idx == IDX_TXHALT) csr_rdata = tx_stat_q;
    if (idx == IDX_RXHALT) csr_rdata = rx_stat_q;
    if (idx[9:3] == IDX_TXBASE[9:3]) csr_rdata = tx_base[idx[2:0]];
    if (idx[9:3] == IDX_TXPTR[9:3])  csr_rdata = tx_ptr[idx[2:0]];
    if (idx[9:3] == IDX_RXBASE[9:3]) csr_rdata = rx_base[idx[2:0]];
    if (idx[9:3] == IDX_RXPTR[9:3])  csr_rdata = rx_ptr[idx[2:0]];
  end

endmodule

// File: rtl/enet_csr_chk.sv
module enet_csr_chk #(
  parameter int NUM_RINGS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 csr_en,
  input logic                 csr_we,
  input logic [11:0]          csr_addr,
  input logic [31:0]          csr_wdata,
  input logic [31:0]          evt_set,
  input logic [NUM_RINGS-1:0] tx_kick,
  input logic [NUM_RINGS-1:0] rx_kick,
  input logic                 irq_tx,
  input logic                 irq_err,
  input logic [31:0]          evt_q,
  input logic [31:0]          rx_stat_q
);

  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_ring
    // R6: a transmit kick only follows a write of 1 to that ring's halt bit
    assert_tx_kick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_kick[i] |-> $past(csr_en && csr_we && (csr_addr[11:2] == 10'd6) && csr_wdata[31-i]));

    // R7: a receive kick only follows a halt bit that was 0
    assert_rx_kick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_kick[i] |-> $past(!rx_stat_q[23-i] && csr_en && csr_we && (csr_addr[11:2] == 10'd7)));
  end

  // R8: a hardware set is never lost to a clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((evt_q & $past(evt_set)) == $past(evt_set)));

  // R9: the transmit interrupt falls only after an event write
  assert_tx_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_tx) |-> $past(csr_en && csr_we && (csr_addr[11:2] == 10'd0)));

  // R10: the error interrupt falls only with every error event clear
  assert_err_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_err) |-> ((evt_q & 32'h0000_1FFC) == 32'h0));

endmodule

bind enet_csr_bank enet_csr_chk #(.NUM_RINGS(NUM_RINGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csr_en    (csr_en),
  .csr_we    (csr_we),
  .csr_addr  (csr_addr),
  .csr_wdata (csr_wdata),
  .evt_set   (evt_set),
  .tx_kick   (tx_kick),
  .rx_kick   (rx_kick),
  .irq_tx    (irq_tx),
  .irq_err   (irq_err),
  .evt_q     (evt_q),
  .rx_stat_q (rx_stat_q)
);

// File: tb/sim_enet_csr_bank.sv
`timescale 1ns/1ps
module sim_enet_csr_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, eset = '0;
  logic [7:0]  txhs = '0, rxhs = '0;
  logic [31:0] rdata, ctrl_w, cmd_w;
  logic [7:0]  txk, rxk;
  logic        itx, irx, ierr;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  enet_csr_bank u0 (
    .clk(clk), .rst_n(rst_n), .csr_en(en), .csr_we(we), .csr_addr(addr),
    .csr_wdata(wdata), .csr_rdata(rdata), .evt_set(eset),
    .tx_halt_set(txhs), .rx_halt_set(rxhs), .tx_kick(txk), .rx_kick(rxk),
    .irq_tx(itx), .irq_rx(irx), .irq_err(ierr), .ctrl_word(ctrl_w), .cmd_word(cmd_w)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] mreg [0:1023];
  logic [7:0]  m_txk, m_rxk;
  logic        m_itx, m_irx, m_ierr;

  // 0 unknown, 1 rw, 2 wo, 3 w1c, 4 ro, 5 ring base, 6 special
  function automatic int cls(int k);
    if (k == 0 || k == 6 || k == 7) return 6;
    if (k == 1 || k == 2) return 1;
    if (k == 3) return 2;
    if (k == 4) return 4;
    if (k == 5) return 3;
    if ((k >= 8 && k < 16) || (k >= 24 && k < 32)) return 5;
    if ((k >= 16 && k < 24) || (k >= 32 && k < 40)) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] mread(int k);
    if (cls(k) == 0 || cls(k) == 2) return 32'h0;
    return mreg[k];
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 1024; k++) mreg[k] = 32'h0;
    mreg[2] = 32'h0000_0040;
    mreg[4] = 32'h5E7C_0001;
    mreg[5] = 32'h0000_FFFF;
    m_txk = 0; m_rxk = 0; m_itx = 0; m_irx = 0; m_ierr = 0;
  endtask

  task automatic model_step();
    int k = int'(addr[11:2]);
    bit wr = en && we;
    logic [31:0] msk = mreg[1];
    logic [31:0] ev = mreg[0];
    logic [31:0] ts = mreg[6];
    logic [31:0] rs = mreg[7];
    bit ew = wr && (k == 0);
    m_txk = 0; m_rxk = 0;
    if (ew) ev = ev & ~wdata;
    ev = ev | eset;
    m_itx  = (m_itx  || (eset[0] && msk[0])) && !(ew && !ev[0]);
    m_irx  = (m_irx  || (eset[1] && msk[1])) && !(ew && !ev[1]);
    m_ierr = (m_ierr || ((eset & msk & 32'h1FFC) != 0)) && !(ew && ((ev & 32'h1FFC) == 0));
    mreg[0] = ev;
    if (wr && k == 6) begin
      for (int r = 0; r < 8; r++) if (wdata[31-r]) m_txk[r] = 1;
      ts = ts & ~wdata;
    end
    for (int r = 0; r < 8; r++) if (txhs[r]) ts[31-r] = 1;
    mreg[6] = ts & 32'hFF00_0000;
    if (wr && k == 7) begin
      for (int r = 0; r < 8; r++) if (wdata[23-r] && !mreg[7][23-r]) m_rxk[r] = 1;
      rs = rs & ~wdata;
    end
    for (int r = 0; r < 8; r++) if (rxhs[r]) rs[23-r] = 1;
    mreg[7] = rs & 32'h00FF_0000;
    if (wr) begin
      case (cls(k))
        1, 2: mreg[k] = wdata;
        3:    mreg[k] = mreg[k] & ~wdata;
        5: begin mreg[k] = wdata & ~32'h7; mreg[k+8] = wdata & ~32'h7; end
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // ---------------- checking helpers ----------------
  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one clock, then compare everything with the reference
  task automatic cyc();
    @(posedge clk); #2;
    chk("R6 kick vs model", {24'h0, txk}, {24'h0, m_txk});
    chk("R7 kick vs model", {24'h0, rxk}, {24'h0, m_rxk});
    chk("R9 irq vs model", {30'h0, itx, irx}, {30'h0, m_itx, m_irx});
    chk("R10 irq vs model", {31'h0, ierr}, {31'h0, m_ierr});
    chk("R2 cmd_word vs model", cmd_w, mreg[3]);
    chk("R3 read vs model", rdata, mread(int'(addr[11:2])));
  endtask

  task automatic wr_reg(logic [11:0] a, logic [31:0] d);
    en = 1; we = 1; addr = a; wdata = d;
    cyc();
    en = 0; we = 0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    en = 1; we = 0; addr = a; #1;
    chk(req, rdata, exp);
    en = 0;
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    // R11 reset state
    chk("R11 kicks", {txk, rxk}, 16'h0);
    chk("R11 irqs", {29'h0, itx, irx, ierr}, 32'h0);
    rd_chk("R11 ctrl", 12'h008, 32'h0000_0040);
    rd_chk("R11 id", 12'h010, 32'h5E7C_0001);
    rd_chk("R11 sticky", 12'h014, 32'h0000_FFFF);
    rd_chk("R11 events", 12'h000, 32'h0);
    rd_chk("R11 tx base", 12'h020, 32'h0);
    rd_chk("R11 unknown", 12'h800, 32'h0);
    cyc();

    // R3 read-write, read-only, unknown
    wr_reg(12'h008, 32'hDEAD_BEEF);
    rd_chk("R3 ctrl rw", 12'h008, 32'hDEAD_BEEF);
    chk("R3 ctrl_word", ctrl_w, 32'hDEAD_BEEF);
    wr_reg(12'h010, 32'h1111_1111);
    rd_chk("R3 id ignores write", 12'h010, 32'h5E7C_0001);
    wr_reg(12'h190, 32'hFFFF_FFFF);
    rd_chk("R3 unknown reads zero", 12'h190, 32'h0);

    // R1 low address bits ignored
    wr_reg(12'h00B, 32'h0000_1234);
    rd_chk("R1 word index", 12'h009, 32'h0000_1234);

    // R2 write-only
    wr_reg(12'h00C, 32'hCAFE_0042);
    rd_chk("R2 wo reads zero", 12'h00C, 32'h0);
    chk("R2 cmd_word", cmd_w, 32'hCAFE_0042);

    // R4 write-1-to-clear
    wr_reg(12'h014, 32'h0000_00F0);
    rd_chk("R4 sticky clear", 12'h014, 32'h0000_FF0F);

    // R5 ring base alignment and copy
    wr_reg(12'h02C, 32'h1234_567F);
    rd_chk("R5 tx base 3", 12'h02C, 32'h1234_5678);
    rd_chk("R5 tx ptr 3", 12'h04C, 32'h1234_5678);
    wr_reg(12'h04C, 32'h0000_0ABC);
    rd_chk("R5 ptr rw", 12'h04C, 32'h0000_0ABC);
    wr_reg(12'h07C, 32'hFFFF_FFFF);
    rd_chk("R5 rx base 7", 12'h07C, 32'hFFFF_FFF8);
    rd_chk("R5 rx ptr 7", 12'h09C, 32'hFFFF_FFF8);

    // R6 transmit halt
    txhs = 8'b0000_0101; cyc(); txhs = 0;
    rd_chk("R6 halt set", 12'h018, 32'hA000_0000);
    wr_reg(12'h018, 32'hA000_0000);
    chk("R6 kick rings 0,2", {24'h0, txk}, 32'h05);
    rd_chk("R6 cleared", 12'h018, 32'h0);
    cyc();
    chk("R6 pulse one cycle", {24'h0, txk}, 32'h0);
    wr_reg(12'h018, 32'h4000_0000);
    chk("R6 kick when clear", {24'h0, txk}, 32'h02);

    // R7 receive halt
    rxhs = 8'b0000_0010; cyc(); rxhs = 0;
    rd_chk("R7 halt set", 12'h01C, 32'h0040_0000);
    wr_reg(12'h01C, 32'h00C0_0000);
    chk("R7 kick only clear bit", {24'h0, rxk}, 32'h01);
    rd_chk("R7 cleared", 12'h01C, 32'h0);

    // R8 / R9 events and frame interrupts
    wr_reg(12'h004, 32'h0000_1F7F);
    eset = 32'h1; cyc(); eset = 0;
    chk("R9 irq_tx raised", {31'h0, itx}, 32'h1);
    wr_reg(12'h000, 32'h1);
    chk("R9 irq_tx lowered", {31'h0, itx}, 32'h0);
    eset = 32'h2; wr_reg(12'h000, 32'h2); eset = 0;
    rd_chk("R8 set beats clear", 12'h000, 32'h2);
    chk("R9 irq_rx held", {31'h0, irx}, 32'h1);
    wr_reg(12'h000, 32'h2);
    chk("R9 irq_rx lowered", {31'h0, irx}, 32'h0);

    // R10 error interrupt
    eset = 32'h80; cyc(); eset = 0;
    chk("R10 masked no raise", {31'h0, ierr}, 32'h0);
    eset = 32'h0010_0000; cyc(); eset = 0;
    chk("R10 status bit no irq", {29'h0, itx, irx, ierr}, 32'h0);
    eset = 32'h24; cyc(); eset = 0;
    chk("R10 raised", {31'h0, ierr}, 32'h1);
    wr_reg(12'h000, 32'h4);
    chk("R10 held bit5", {31'h0, ierr}, 32'h1);
    wr_reg(12'h000, 32'h20);
    chk("R10 held masked bit7", {31'h0, ierr}, 32'h1);
    wr_reg(12'h000, 32'h80);
    chk("R10 lowered", {31'h0, ierr}, 32'h0);
    rd_chk("R8 remaining", 12'h000, 32'h0010_0000);

    // mixed traffic against the reference
    for (int n = 0; n < 3000; n++) begin
      int pick = $urandom_range(0, 47);
      en    = ($urandom_range(0, 3) != 0);
      we    = $urandom_range(0, 1);
      addr  = {pick[9:0], 2'($urandom_range(0, 3))};
      wdata = $urandom();
      eset  = ($urandom_range(0, 5) == 0) ? ($urandom() & 32'h0010_1FFF) : 32'h0;
      txhs  = ($urandom_range(0, 7) == 0) ? 8'($urandom()) : 8'h0;
      rxhs  = ($urandom_range(0, 7) == 0) ? 8'($urandom()) : 8'h0;
      cyc();
    end
    en = 0; we = 0; eset = 0; txhs = 0; rxhs = 0;
    cyc();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule